// File: doc/BRIEF.md
# Program/Erase Status Byte Generator

This block supplies the byte a reader sees from a byte-wide flash array while an internal program or erase job is running. The controller reports the start of a job (after its final command write), whether it is an erase, the most significant bit of the byte being written, whether every target block is write-protected, and later a completion or a failure pulse. On each read strobe the block answers either with the array byte passed through (no job active) or with a synthesized status byte. That byte carries a polling bit, a toggle bit that flips on each read, a failure bit and an erase-timer bit.

A job aimed only at protected blocks behaves differently by kind. A protected erase shows a short imitation of busy status lasting a parameterized number of clock cycles, then reverts to array data. A protected program is dropped with no visible effect. A failure freezes the status until the controller issues its reset command. For DATA_W = 8 the polling, toggle, failure and timer bits sit at positions 7, 6, 5 and 3; in general they are DATA_W-1, DATA_W-2, DATA_W-3 and DATA_W-5.

Top module: `pesg_status_gen`

## Requirements
- R1: After synchronous reset `rd_valid` is 0, `rd_data` is 0 and the block is idle, so the first read returns array data.
- R2: Each `rd_strobe` produces `rd_valid` high exactly one cycle later with the byte for that read in `rd_data`; when idle that byte equals `array_rd` of the strobe cycle, and `rd_data` holds between reads.
- R3: While a program job runs, bit 7 reads as the complement of the latched `start_msb`, bit 5 reads 0 and bit 3 reads 0.
- R4: While an erase job runs, bit 7 reads 0 and bit 3 reads the inverse of `erase_win_open` in the strobe cycle (0 while the entry window is open, 1 after it closes).
- R5: An accepted start clears the toggle bit; every read during a running job or a protected-erase window returns bit 6 and then inverts it, so the first read gives 0 and successive reads alternate.
- R6: During an erase job with `erase_suspend` high, reads do not change bit 6.
- R7: `op_fail` during a running job moves to a fault state in which bit 5 reads 1, bit 6 stops changing and bit 7 keeps its running value, until `ctl_reset`.
- R8: `op_done` during a running job returns the block to idle, so the next read returns array data.
- R9: An erase start with `target_prot` high shows status for FAKE_CYC cycles (bit 7 = 0, bit 6 toggling, bit 5 = 0, bit 3 = 1), then returns to idle by itself.
- R10: A program start with `target_prot` high is ignored: the block stays idle and reads return array data.
- R11: `ctl_reset` returns the block to idle from any state, clearing a fault.
- R12: `start` is ignored unless the block is idle.
- R13: Bits 4, 2, 1 and 0 of every status byte read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: job sequence fully written |
| start_erase | input | 1 | Job kind at start: 1 erase, 0 program |
| start_msb | input | 1 | Most significant bit of the byte to be programmed |
| target_prot | input | 1 | All target blocks of the starting job are protected |
| op_done | input | 1 | One-cycle pulse: running job finished successfully |
| op_fail | input | 1 | One-cycle pulse: running job exceeded its limits |
| ctl_reset | input | 1 | Controller reset command |
| erase_win_open | input | 1 | Multi-block erase entry window still open |
| erase_suspend | input | 1 | Erase suspend acknowledged |
| rd_strobe | input | 1 | One read of the array |
| array_rd | input | DATA_W | Byte read from the array |
| rd_data | output | DATA_W | Byte returned for the last read |
| rd_valid | output | 1 | `rd_data` updated in this cycle |

## Verification
On every cycle the assertions check the read timing, idle pass-through, the erase polling bit, the fault flag, the reserved-bit zeros, the state effect of failure and controller reset, and that a protected program leaves the block idle. The toggle sequence across reads, its freezing under suspend and fault, the timer bit following the window, the length of the protected-erase window and the polling complement for each target bit are shown by the bench's scenarios against its per-cycle reference model.

// File: rtl/pesg_pkg.sv
package pesg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAKE  = 2'd2,
    ST_FAULT = 2'd3
  } pe_state_t;
endpackage

// File: rtl/pesg_sequencer.sv
module pesg_sequencer
  import pesg_pkg::*;
#(
  parameter int FAKE_CYC = 5000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      start_erase,
  input  logic      start_msb,
  input  logic      target_prot,
  input  logic      op_done,
  input  logic      op_fail,
  input  logic      ctl_reset,
  output pe_state_t state_q,
  output logic      erase_q,
  output logic      msb_q,
  output logic      accept
);
  localparam int CNT_W = (FAKE_CYC > 1) ? $clog2(FAKE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FAKE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  // A start is taken only when idle and not a protected program.
  assign accept = (state_q == ST_IDLE) && start && !ctl_reset &&
                  (!target_prot || start_erase);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      erase_q <= 1'b0;
      msb_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (ctl_reset) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            erase_q <= start_erase;
            msb_q   <= start_msb;
            if (target_prot) begin
              state_q <= ST_FAKE;
              cnt_q   <= CNT_LOAD;
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (op_fail)      state_q <= ST_FAULT;
          else if (op_done) state_q <= ST_IDLE;
        end
        ST_FAKE: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_FAULT: begin
          state_q <= ST_FAULT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pesg_toggle.sv
module pesg_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic tog_q
);
  always_ff @(posedge clk) begin
    if (rst)       tog_q <= 1'b0;
    else if (clear) tog_q <= 1'b0;
    else if (step)  tog_q <= ~tog_q;
  end
endmodule

// File: rtl/pesg_byte_fmt.sv
module pesg_byte_fmt
  import pesg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  pe_state_t         state,
  input  logic              erase,
  input  logic              msb,
  input  logic              tog,
  input  logic              win_open,
  input  logic [DATA_W-1:0] array_rd,
  output logic [DATA_W-1:0] byte_out
);
  localparam int POLL = DATA_W - 1;
  localparam int TOGB = DATA_W - 2;
  localparam int ERRB = DATA_W - 3;
  localparam int TMRB = DATA_W - 5;

  logic [DATA_W-1:0] stat;

  always_comb begin
    stat       = '0;
    stat[POLL] = (state == ST_FAKE || erase) ? 1'b0 : ~msb;
    stat[TOGB] = tog;
    stat[ERRB] = (state == ST_FAULT);
    stat[TMRB] = (state == ST_FAKE) ? 1'b1 : (erase ? ~win_open : 1'b0);
    byte_out   = (state == ST_IDLE) ? array_rd : stat;
  end
endmodule

// File: rtl/pesg_status_gen.sv
module pesg_status_gen
  import pesg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FAKE_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_erase,
  input  logic              start_msb,
  input  logic              target_prot,
  input  logic              op_done,
  input  logic              op_fail,
  input  logic              ctl_reset,
  input  logic              erase_win_open,
  input  logic              erase_suspend,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  pe_state_t         st_q;
  logic              erase_q, msb_q, accept, tog_q, tog_step;
  logic [DATA_W-1:0] byte_now;

  pesg_sequencer #(.FAKE_CYC(FAKE_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_erase(start_erase),
    .start_msb(start_msb), .target_prot(target_prot), .op_done(op_done),
    .op_fail(op_fail), .ctl_reset(ctl_reset), .state_q(st_q),
    .erase_q(erase_q), .msb_q(msb_q), .accept(accept)
  );

  assign tog_step = rd_strobe &&
                    ((st_q == ST_RUN && !(erase_suspend && erase_q)) ||
                     st_q == ST_FAKE);

  pesg_toggle u_tog (
    .clk(clk), .rst(rst), .clear(accept), .step(tog_step), .tog_q(tog_q)
  );

  pesg_byte_fmt #(.DATA_W(DATA_W)) u_fmt (
    .state(st_q), .erase(erase_q), .msb(msb_q), .tog(tog_q),
    .win_open(erase_win_open), .array_rd(array_rd), .byte_out(byte_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) rd_data <= byte_now;
    end
  end
endmodule

// File: rtl/pesg_status_gen_chk.sv
module pesg_status_gen_chk
  import pesg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_strobe,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] array_rd,
  input logic              start,
  input logic              start_erase,
  input logic              target_prot,
  input logic              op_fail,
  input logic              ctl_reset,
  input pe_state_t         state,
  input logic              erase_q
);
  localparam int POLL = DATA_W - 1;
  localparam int ERRB = DATA_W - 3;
  localparam logic [DATA_W-1:0] KEEP =
    DATA_W'((1 << (DATA_W-1)) | (1 << (DATA_W-2)) | (1 << (DATA_W-3)) | (1 << (DATA_W-5)));
  localparam logic [DATA_W-1:0] RSV_MASK = ~KEEP;

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> rd_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> !rd_valid);
  assert_idle_passthrough_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && state == ST_IDLE) |=> rd_data == $past(array_rd));
  assert_erase_poll_low_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && state == ST_RUN && erase_q) |=> !rd_data[POLL]);
  assert_fault_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && state == ST_FAULT) |=> rd_data[ERRB]);
  assert_fail_latches_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && op_fail && !ctl_reset) |=> state == ST_FAULT);
  assert_reserved_zero_R13: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && state != ST_IDLE) |=> (rd_data & RSV_MASK) == '0);
  assert_reset_cmd_idle_R11: assert property (@(posedge clk) disable iff (rst)
    ctl_reset |=> state == ST_IDLE);
  assert_prot_prog_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && target_prot && !start_erase) |=> state == ST_IDLE);
endmodule

bind pesg_status_gen pesg_status_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_valid(rd_valid),
  .rd_data(rd_data), .array_rd(array_rd), .start(start),
  .start_erase(start_erase), .target_prot(target_prot), .op_fail(op_fail),
  .ctl_reset(ctl_reset), .state(st_q), .erase_q(erase_q)
);

// File: tb/sim_pesg_status_gen.sv
module sim_pesg_status_gen;
  localparam int CLK_PERIOD = 10;
  localparam int FAKE_CYC   = 12;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 0, start_erase = 0, start_msb = 0, target_prot = 0;
  logic       op_done = 0, op_fail = 0, ctl_reset = 0;
  logic       erase_win_open = 0, erase_suspend = 0, rd_strobe = 0;
  logic [7:0] array_rd = 8'h00;
  logic [7:0] rd_data;
  logic       rd_valid;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pesg_status_gen #(.DATA_W(8), .FAKE_CYC(FAKE_CYC)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_erase(start_erase),
    .start_msb(start_msb), .target_prot(target_prot), .op_done(op_done),
    .op_fail(op_fail), .ctl_reset(ctl_reset), .erase_win_open(erase_win_open),
    .erase_suspend(erase_suspend), .rd_strobe(rd_strobe), .array_rd(array_rd),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Behavioural reference: 0 idle, 1 running, 2 protected-erase window, 3 fault
  int     m_mode = 0, m_cnt = 0;
  bit     m_erase = 0, m_msb = 0, m_tog = 0;
  logic [7:0] e_data = 0;
  bit     e_valid = 0;
  string  e_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_erase = 0; m_msb = 0; m_tog = 0; m_cnt = 0;
      e_data = 0; e_valid = 0; e_tag = "R1";
    end else begin
      e_valid = rd_strobe;
      if (rd_strobe) begin
        if (m_mode == 0) begin
          e_data = array_rd; e_tag = "R2";
        end else begin
          e_data = 8'h00;
          e_data[7] = (m_mode == 2 || m_erase) ? 1'b0 : !m_msb;
          e_data[6] = m_tog;
          e_data[5] = (m_mode == 3);
          e_data[3] = (m_mode == 2) ? 1'b1 : (m_erase ? !erase_win_open : 1'b0);
          e_tag = (m_mode == 2) ? "R9" : (m_mode == 3) ? "R7" : (m_erase ? "R4" : "R3");
        end
        if ((m_mode == 1 && !(erase_suspend && m_erase)) || m_mode == 2) m_tog = !m_tog;
      end else e_tag = "R2";
      if (ctl_reset) m_mode = 0;
      else if (m_mode == 0) begin
        if (start && !(target_prot && !start_erase)) begin
          m_erase = start_erase; m_msb = start_msb; m_tog = 0;
          if (target_prot) begin m_mode = 2; m_cnt = FAKE_CYC - 1; end
          else m_mode = 1;
        end
      end else if (m_mode == 1) begin
        if (op_fail) m_mode = 3; else if (op_done) m_mode = 0;
      end else if (m_mode == 2) begin
        if (m_cnt == 0) m_mode = 0; else m_cnt--;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check(rd_valid == e_valid, {e_tag, " valid"}, rd_valid, e_valid);
      check(rd_data == e_data, {e_tag, " data"}, rd_data, e_data);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic rd(input logic [7:0] arr, output logic [7:0] v);
    array_rd = arr; rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0; v = rd_data;
  endtask

  task automatic go(input bit er, input bit msb, input bit prot);
    start = 1; start_erase = er; start_msb = msb; target_prot = prot;
    @(negedge clk);
    start = 0; target_prot = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [7:0] a, b;

  initial begin
    idle(3);
    check(rd_valid == 0, "R1 valid", rd_valid, 0);
    check(rd_data == 0, "R1 data", rd_data, 0);
    rst = 0;
    idle(1);
    rd(8'h5A, a); check(a == 8'h5A, "R1 first read", a, 8'h5A);
    rd(8'hC3, a); check(a == 8'hC3, "R2 idle read", a, 8'hC3);
    idle(2); check(rd_data == 8'hC3 && !rd_valid, "R2 hold", rd_data, 8'hC3);

    // program, target msb 1
    go(0, 1, 0);
    rd(8'hFF, a); rd(8'hFF, b);
    check(a[7] == 0, "R3 poll complement", a[7], 0);
    check(a[6] == 0 && b[6] == 1, "R5 toggle sequence", {a[6], b[6]}, 2'b01);
    check((a & 8'h17) == 0, "R13 reserved", a & 8'h17, 0);
    check(a[5] == 0 && a[3] == 0, "R3 err and timer", {a[5], a[3]}, 0);
    go(1, 0, 0);  // ignored while running
    rd(8'hFF, a); check(a[7] == 0 && a[6] == 0, "R12 start ignored", a, 8'h00);
    op_done = 1; @(negedge clk); op_done = 0;
    rd(8'h80, a); check(a == 8'h80, "R8 after done", a, 8'h80);

    // program, target msb 0
    go(0, 0, 0);
    rd(8'h00, a); check(a[7] == 1, "R3 poll complement of 0", a[7], 1);
    ctl_reset = 1; @(negedge clk); ctl_reset = 0;
    rd(8'h33, a); check(a == 8'h33, "R11 reset from run", a, 8'h33);

    // erase with window, suspend, failure
    erase_win_open = 1;
    go(1, 0, 0);
    rd(8'hFF, a); check(a[7] == 0 && a[3] == 0, "R4 window open", {a[7], a[3]}, 0);
    erase_win_open = 0;
    rd(8'hFF, a); check(a[3] == 1, "R4 window closed", a[3], 1);
    erase_suspend = 1;
    rd(8'hFF, a); rd(8'hFF, b); check(a[6] == b[6], "R6 suspend hold", b[6], a[6]);
    erase_suspend = 0;
    rd(8'hFF, a); rd(8'hFF, b); check(a[6] != b[6], "R5 resume toggling", b[6], !a[6]);
    op_fail = 1; @(negedge clk); op_fail = 0;
    rd(8'hFF, a); rd(8'hFF, b);
    check(a[5] == 1 && a[7] == 0, "R7 fault flag", a, 8'h28);
    check(a[6] == b[6], "R7 toggle frozen", b[6], a[6]);
    go(0, 1, 0);
    rd(8'h11, a); check(a[5] == 1, "R12 start in fault", a[5], 1);
    ctl_reset = 1; @(negedge clk); ctl_reset = 0;
    rd(8'h11, a); check(a == 8'h11, "R11 fault cleared", a, 8'h11);

    // protected erase window
    go(1, 1, 1);
    rd(8'hAA, a); rd(8'hAA, b);
    check(a[7] == 0 && a[3] == 1 && a[5] == 0, "R9 fake status", a, 8'h08);
    check(a[6] != b[6], "R9 fake toggling", b[6], !a[6]);
    idle(FAKE_CYC);
    rd(8'hAA, a); check(a == 8'hAA, "R9 window ended", a, 8'hAA);

    // protected program
    go(0, 1, 1);
    rd(8'h7E, a); check(a == 8'h7E, "R10 protected program", a, 8'h7E);
    idle(4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule